// File: doc/BRIEF.md
# Double-Buffered Real-Time-Clock Register Window

This block sits between a host read/write port and a set of live timekeeping counters. It claims the top 16 byte addresses of the host address space. Inside that window it holds a shadow copy of seven time fields, a flags byte and a calibration byte. The host always reads the shadow copy. It never reads the counters directly, so a read cannot catch a field while it is rolling over.

The flags byte has two bits:

- **Freeze bit.** While it is set, the shadow copy stops following the counters. The counters keep running. Clearing the bit copies every counter field into the shadow at once, on the same clock edge as the clearing write.
- **Write-enable bit.** While it is set, the shadow stops following the counters and accepts host writes as a new base time. Clearing the bit sends the whole shadow to the counters as a single transfer, marked by a one-cycle load strobe.

While both bits are clear, the shadow copies the counters on every tick pulse.

The calibration byte carries the oscillator disable bit. It resets to 0, which means the oscillator runs.

Top module: `rtc_dbuf_regs`

## Requirements
- R1: Only addresses whose bits above bit 3 are all ones fall in the window. A read outside the window returns 0x00, and a write outside it changes nothing.
- R2: The flags register is at window offset 0x0. Bit 0 is the freeze bit and bit 1 is the write-enable bit. Both bits can be written and read back.
- R3: While both flag bits are 0, a tick pulse copies all seven live fields into the shadow on the same edge. Bits outside each field's mask are cleared.
  - The fields sit at offsets 0x9 to 0xF: seconds, minutes, hours, weekday, date, month, year.
  - Field i uses live input bits [8i+7:8i].
  - The masks are 7F, 7F, 3F, 07, 3F, 1F, FF.
- R4: While the freeze bit is 1, ticks leave the shadow unchanged.
- R5: A flags write that clears the freeze bit and leaves write-enable at 0 loads every shadow field from the live inputs on that edge, without waiting for a tick.
- R6: While write-enable is 1, ticks leave the shadow unchanged. A host write to a time offset stores the written data ANDed with that field's mask.
- R7: While write-enable is 0, host writes to time offsets are ignored.
- R8: A flags write that clears write-enable raises load_o for exactly one cycle after that edge. During that cycle, load_time_o carries the shadow fields as they stood before the clearing write.
- R9: Bit 7 of the calibration register at offset 0x8 is the oscillator disable bit. It drives osc_dis_o and resets to 0, meaning enabled.
- R10: Unused offsets 0x1 to 0x7 read as 0x00, and so does every bit outside a register's defined bits. Writes to those bits and offsets have no effect.
- R11: rdata_o is registered. It updates on the edge where rd_en_i is sampled high and otherwise holds its value.
- R12: After reset, the flags, the calibration byte, the shadow fields, load_o and rdata_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | 8 | Host write data |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| rdata_o | output | 8 | Registered read data |
| tick_i | input | 1 | One-cycle pulse when the live counters advance |
| live_time_i | input | 56 | Live counter fields, 8 bits per field, seconds in the lowest byte |
| load_o | output | 1 | One-cycle strobe that commits the base time to the counters |
| load_time_o | output | 56 | Base time sent to the counters |
| osc_dis_o | output | 1 | Oscillator disable, 1 = stopped |

## Verification
The live inputs are driven in three ways:

- **In-range values with a tick.** These show that plain tracking works.
- **All-ones values.** These separate correct per-field masking from a plain copy.
- **Changed values with no tick, during a freeze and right after it is released.** These separate an immediate refresh on release from one that waits for the next tick.

Host writes to time offsets are tried both with write-enable clear and with it set. This tells an ignored write from an accepted, masked one. The committed word is then compared byte for byte with what the host wrote.

// File: rtl/rtc_dbuf_pkg.sv
package rtc_dbuf_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_TF   = 7;
  localparam int unsigned TIME_W   = REG_W * NUM_TF;
  localparam int unsigned OFF_W    = 4;
  localparam logic [OFF_W-1:0] OFF_FLAGS = 4'h0;
  localparam logic [OFF_W-1:0] OFF_CALIB = 4'h8;
  localparam logic [OFF_W-1:0] OFF_TIME0 = 4'h9;
  localparam int unsigned BIT_RD   = 0;
  localparam int unsigned BIT_WR   = 1;
  localparam int unsigned BIT_OSC  = 7;

  function automatic logic [REG_W-1:0] tf_mask(int unsigned idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [TIME_W-1:0] tf_mask_all();
    logic [TIME_W-1:0] m;
    for (int unsigned i = 0; i < NUM_TF; i++) m[i*REG_W +: REG_W] = tf_mask(i);
    return m;
  endfunction
endpackage

// File: rtl/rtc_dbuf_decode.sv
module rtc_dbuf_decode
  import rtc_dbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              is_flags_o,
  output logic              is_calib_o,
  output logic              is_time_o,
  output logic [2:0]        tidx_o
);
  logic [OFF_W-1:0] rel;

  assign hit_o      = &addr_i[ADDR_W-1:OFF_W];
  assign off_o      = addr_i[OFF_W-1:0];
  assign is_flags_o = hit_o && (off_o == OFF_FLAGS);
  assign is_calib_o = hit_o && (off_o == OFF_CALIB);
  assign is_time_o  = hit_o && (off_o >= OFF_TIME0);
  assign rel        = off_o - OFF_TIME0;
  assign tidx_o     = rel[2:0];
endmodule

// File: rtl/rtc_dbuf_ctrl.sv
module rtc_dbuf_ctrl
  import rtc_dbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             is_flags_i,
  input  logic             is_calib_i,
  output logic             r_o,
  output logic             w_o,
  output logic             osc_dis_o,
  output logic             r_clr_o,
  output logic             w_clr_o
);
  logic r_q, w_q, osc_q;
  logic flag_wr;

  assign flag_wr = wr_en_i && is_flags_i;
  // refresh on release only when no write session stays open
  assign r_clr_o = flag_wr && r_q && !wdata_i[BIT_RD] && !wdata_i[BIT_WR];
  assign w_clr_o = flag_wr && w_q && !wdata_i[BIT_WR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= 1'b0;
      w_q   <= 1'b0;
      osc_q <= 1'b0;
    end else begin
      if (flag_wr) begin
        r_q <= wdata_i[BIT_RD];
        w_q <= wdata_i[BIT_WR];
      end
      if (wr_en_i && is_calib_i) osc_q <= wdata_i[BIT_OSC];
    end
  end

  assign r_o       = r_q;
  assign w_o       = w_q;
  assign osc_dis_o = osc_q;
endmodule

// File: rtl/rtc_dbuf_shadow.sv
module rtc_dbuf_shadow
  import rtc_dbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              r_i,
  input  logic              w_i,
  input  logic              r_clr_i,
  input  logic              wr_time_i,
  input  logic [2:0]        tidx_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [TIME_W-1:0] live_i,
  output logic [TIME_W-1:0] shadow_o
);
  logic refresh;

  assign refresh = (tick_i && !r_i && !w_i) || r_clr_i;

  for (genvar g = 0; g < NUM_TF; g++) begin : g_field
    localparam logic [REG_W-1:0] MSK = tf_mask(g);
    logic [REG_W-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
      end else if (refresh) begin
        sh_q <= live_i[g*REG_W +: REG_W] & MSK;
      end else if (wr_time_i && w_i && (tidx_i == 3'(g))) begin
        sh_q <= wdata_i & MSK;
      end
    end
    assign shadow_o[g*REG_W +: REG_W] = sh_q;
  end
endmodule

// File: rtl/rtc_dbuf_commit.sv
module rtc_dbuf_commit
  import rtc_dbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              w_clr_i,
  input  logic [TIME_W-1:0] shadow_i,
  output logic              load_o,
  output logic [TIME_W-1:0] load_time_o
);
  logic              load_q;
  logic [TIME_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      base_q <= '0;
    end else begin
      load_q <= w_clr_i;
      if (w_clr_i) base_q <= shadow_i;
    end
  end

  assign load_o      = load_q;
  assign load_time_o = base_q;
endmodule

// File: rtl/rtc_dbuf_regs.sv
module rtc_dbuf_regs
  import rtc_dbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic [55:0]       live_time_i,
  output logic              load_o,
  output logic [55:0]       load_time_o,
  output logic              osc_dis_o
);
  logic             hit, is_flags, is_calib, is_time;
  logic [OFF_W-1:0] off;
  logic [2:0]       tidx;
  logic             r_q, w_q, r_clr, w_clr;
  logic [TIME_W-1:0] shadow;
  logic [REG_W-1:0] rd_val, rdata_q;

  rtc_dbuf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .hit_o(hit), .off_o(off), .is_flags_o(is_flags),
    .is_calib_o(is_calib), .is_time_o(is_time), .tidx_o(tidx)
  );

  rtc_dbuf_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .is_flags_i(is_flags), .is_calib_i(is_calib), .r_o(r_q), .w_o(w_q),
    .osc_dis_o(osc_dis_o), .r_clr_o(r_clr), .w_clr_o(w_clr)
  );

  rtc_dbuf_shadow u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .r_i(r_q), .w_i(w_q),
    .r_clr_i(r_clr), .wr_time_i(wr_en_i && is_time), .tidx_i(tidx),
    .wdata_i(wdata_i), .live_i(live_time_i), .shadow_o(shadow)
  );

  rtc_dbuf_commit u_cmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .w_clr_i(w_clr), .shadow_i(shadow),
    .load_o(load_o), .load_time_o(load_time_o)
  );

  always_comb begin
    rd_val = '0;
    if (is_flags) begin
      rd_val[BIT_RD] = r_q;
      rd_val[BIT_WR] = w_q;
    end else if (is_calib) begin
      rd_val[BIT_OSC] = osc_dis_o;
    end else if (is_time) begin
      rd_val = shadow[tidx*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= hit ? rd_val : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtc_dbuf_regs_chk.sv
module rtc_dbuf_regs_chk
  import rtc_dbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [7:0]        rdata_o,
  input logic [55:0]       live_time_i,
  input logic              load_o,
  input logic              osc_dis_o,
  input logic              r_q,
  input logic              w_q,
  input logic [55:0]       shadow
);
  logic [55:0] live_m;
  logic        rd_flags;

  assign live_m   = live_time_i & tf_mask_all();
  assign rd_flags = rd_en_i && (&addr_i[ADDR_W-1:OFF_W]) && (addr_i[OFF_W-1:0] == OFF_FLAGS);

  // R8
  p_load_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  // R8
  p_load_on_wclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_o) |-> $fell(w_q));
  // R4
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_q && $past(r_q) && !w_q && !$past(w_q)) |-> $stable(shadow));
  // R5
  p_release_refresh_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(r_q) && !w_q) |-> (shadow == $past(live_m)));
  // R9
  p_osc_by_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(osc_dis_o) |-> $past(wr_en_i));
  // R10
  p_flags_rsvd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_flags) |-> (rdata_o[7:2] == 6'd0));
  // R11
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rdata_o));
endmodule

bind rtc_dbuf_regs rtc_dbuf_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .rdata_o(rdata_o), .live_time_i(live_time_i),
  .load_o(load_o), .osc_dis_o(osc_dis_o), .r_q(r_q), .w_q(w_q), .shadow(shadow)
);

// File: tb/rtc_dbuf_regs_test.sv
module rtc_dbuf_regs_test;
  localparam int unsigned ADDR_W = 19;
  localparam logic [ADDR_W-5:0] WIN = '1;

  typedef struct packed {
    logic       rd;
    logic [3:0] off;
    logic [7:0] dat;
  } vec_t;

  // R2 R6 R7 R9 R10 R12 exercised by this table
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 8'h00},  // R12 flags reset
    '{1'b1, 4'h8, 8'h00},  // R12 calib reset
    '{1'b1, 4'h9, 8'h00},  // R12 shadow reset
    '{1'b0, 4'h8, 8'hFF},
    '{1'b1, 4'h8, 8'h80},  // R9 R10 only bit 7 kept
    '{1'b0, 4'h8, 8'h00},
    '{1'b1, 4'h8, 8'h00},
    '{1'b0, 4'h9, 8'h45},
    '{1'b1, 4'h9, 8'h00},  // R7 ignored while W=0
    '{1'b0, 4'h0, 8'hFF},
    '{1'b1, 4'h0, 8'h03},  // R2 R10
    '{1'b0, 4'h9, 8'hFF},
    '{1'b1, 4'h9, 8'h7F},  // R6 masked
    '{1'b0, 4'hB, 8'h23},
    '{1'b1, 4'hB, 8'h23},  // R6
    '{1'b0, 4'h3, 8'hAA},
    '{1'b1, 4'h3, 8'h00}   // R10 unused offset
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic              wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0]        rdata;
  logic [55:0]       live = '0;
  logic              load, osc_dis;
  logic [55:0]       load_time;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_dbuf_regs #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .rdata_o(rdata), .tick_i(tick), .live_time_i(live),
    .load_o(load), .load_time_o(load_time), .osc_dis_o(osc_dis)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_abs(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_abs(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(logic [3:0] o, logic [7:0] d); wr_abs({WIN, o}, d); endtask
  task automatic rd(logic [3:0] o, output logic [7:0] d); rd_abs({WIN, o}, d); endtask

  task automatic do_tick(logic [55:0] v);
    @(negedge clk); live = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [55:0] la, lb, lbm;
    la  = 56'h24_02_28_03_15_34_12;
    lb  = 56'hFF_FF_FF_FF_FF_FF_FF;
    lbm = 56'hFF_1F_3F_07_3F_7F_7F;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 load", 64'(load), 64'd0);
    chk("R12 osc", 64'(osc_dis), 64'd0);
    chk("R12 rdata", 64'(rdata), 64'd0);
    rst_n = 1'b1;
    live = la;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        rd(VECS[i].off, d);
        chk($sformatf("table[%0d]", i), 64'(d), 64'(VECS[i].dat));
      end else begin
        wr(VECS[i].off, VECS[i].dat);
      end
    end

    // R9 pin
    wr(4'h8, 8'h80);
    chk("R9 osc_dis set", 64'(osc_dis), 64'd1);
    wr(4'h8, 8'h00);
    chk("R9 osc_dis clear", 64'(osc_dis), 64'd0);

    // R8 commit: clear W, keep R
    wr(4'h0, 8'h01);
    chk("R8 load pulse", 64'(load), 64'd1);
    chk("R8 load value", 64'(load_time), 64'h0000_0000_2300_7F);
    @(negedge clk);
    chk("R8 load single", 64'(load), 64'd0);

    // R4 frozen while R=1
    do_tick(la);
    rd(4'h9, d);
    chk("R4 frozen", 64'(d), 64'h7F);

    // R5 release refreshes without tick
    wr(4'h0, 8'h00);
    for (int i = 0; i < 7; i++) begin
      rd(4'(9 + i), d);
      chk($sformatf("R5 field %0d", i), 64'(d), 64'(la[i*8 +: 8]));
    end

    // R3 tracking with masks
    do_tick(lb);
    for (int i = 0; i < 7; i++) begin
      rd(4'(9 + i), d);
      chk($sformatf("R3 field %0d", i), 64'(d), 64'(lbm[i*8 +: 8]));
    end

    // R1 outside window
    wr_abs(19'h00008, 8'h80);
    rd(4'h8, d);
    chk("R1 outside write", 64'(d), 64'd0);
    chk("R1 outside osc", 64'(osc_dis), 64'd0);
    rd(4'hF, d);
    chk("R1 prior read", 64'(d), 64'hFF);
    rd_abs(19'h0000F, d);
    chk("R1 outside read", 64'(d), 64'd0);

    // R6 tick ignored while W=1
    wr(4'h0, 8'h02);
    do_tick(la);
    rd(4'h9, d);
    chk("R6 tick frozen", 64'(d), 64'h7F);
    wr(4'h0, 8'h00);
    chk("R8 second load", 64'(load), 64'd1);
    chk("R8 second value", 64'(load_time), 64'(lbm));

    // R11 rdata holds without rd_en
    rd(4'hE, d);
    chk("R11 read", 64'(d), 64'h1F);
    do_tick(la);
    @(negedge clk);
    chk("R11 hold", 64'(rdata), 64'h1F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule